// File: doc/BRIEF.md
# Audio Automatic Gain Controller

This block sets the gain code of a programmable amplifier in an audio capture path. It watches the signed samples that leave the converter, measures their level with a windowed peak detector, and compares that level with a programmable target. Loud material lowers the gain and quiet material raises it. Each direction has its own programmable spacing between updates. Gain is expressed in half-decibel units from 0 dB to 40 dB.

Every gain change is a soft step of a single code per accepted sample, so the amplifier never sees an abrupt jump while the loop is running. A dead band around the target stops the loop from hunting between two codes. When the loop is disabled, the gain is pinned to a programmable fixed code. Settings arrive on plain input ports.

Top module: `agc_gain_ctrl`

## Requirements
- R1: After reset is released, `gain_o` reads code 0 (one code equals 0.5 dB).
- R2: `gain_o` stays within 0 to 80 inclusive and saturates at both ends without wrapping.
- R3: While `enable_i` is high, `gain_o` changes by at most one code per clock, and only on a clock where `sample_vld_i` is high.
- R4: While the measured level exceeds `target_i + (target_i >> 4)`, the gain falls by one code on every (`attack_i`+1)-th valid sample, counted from the later of the enable or the start of the loud condition.
- R5: While the measured level is below `target_i - (target_i >> 4)`, the gain rises by one code on every (`decay_i`+1)-th valid sample, counted the same way.
- R6: While the measured level lies inside that band (limits inclusive), the gain holds.
- R7: The measured level is the largest absolute sample value in each run of 256 consecutive valid samples after reset. It is updated at the clock of the window's last sample and is held in between.
- R8: While `enable_i` is low, `gain_o` equals `fixed_gain_i`, or 80 when `fixed_gain_i` exceeds 80, from the next clock on. Both step counters restart from zero.
- R9: A clock without `sample_vld_i` leaves the gain, the counters and the level untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable_i | input | 1 | Loop enable; low pins the gain to the fixed code |
| sample_vld_i | input | 1 | Sample strobe |
| sample_i | input | SAMPLE_W | Signed two's-complement audio sample |
| target_i | input | SAMPLE_W | Target magnitude |
| attack_i | input | TIME_W | Valid samples minus one between downward steps |
| decay_i | input | TIME_W | Valid samples minus one between upward steps |
| fixed_gain_i | input | 7 | Gain code used while the loop is disabled |
| gain_o | output | 7 | Gain code in half-decibel units |

## Verification
Assertions check on every clock that the code stays in range and moves by no more than one. They also check that it holds without a strobe and inside the band, that it moves only in the allowed direction while loud or quiet, that it follows the clamped fixed code while disabled, and that the level changes only at window ends. The exact step spacing for a given attack or decay setting, saturation after a long run, and the delay of one whole window before the level reacts to new material can only be shown by the bench's scenarios. Those scenarios compare final codes with values worked out from the sample counts.

// File: rtl/agc_pkg.sv
package agc_pkg;
  localparam int GAIN_MAX_CODE = 80;
  localparam int GAIN_W        = $clog2(GAIN_MAX_CODE + 1);
  localparam int DIR_DOWN      = 0;
  localparam int DIR_UP        = 1;
  localparam int DIR_COUNT     = 2;
endpackage

// File: rtl/agc_peak_meter.sv
module agc_peak_meter #(
  parameter int SAMPLE_W = 16,
  parameter int WIN_LEN  = 256
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  output logic        [SAMPLE_W-1:0] level_o
);
  localparam int WIN_W = $clog2(WIN_LEN);

  logic [WIN_W-1:0]    win_q, win_nxt;
  logic [SAMPLE_W-1:0] run_q, run_nxt;
  logic [SAMPLE_W-1:0] lvl_q, lvl_nxt;
  logic [SAMPLE_W-1:0] mag, mag_max;
  logic                win_last;

  always_comb begin
    mag      = sample_i[SAMPLE_W-1] ? (~sample_i + 1'b1) : sample_i;
    mag_max  = (mag > run_q) ? mag : run_q;
    win_last = (win_q == WIN_W'(WIN_LEN - 1));
    win_nxt  = win_q;
    run_nxt  = run_q;
    lvl_nxt  = lvl_q;
    if (tick_i) begin
      if (win_last) begin
        lvl_nxt = mag_max;
        run_nxt = '0;
        win_nxt = '0;
      end else begin
        run_nxt = mag_max;
        win_nxt = win_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      run_q <= '0;
      lvl_q <= '0;
    end else if (tick_i) begin
      win_q <= win_nxt;
      run_q <= run_nxt;
      lvl_q <= lvl_nxt;
    end
  end

  assign level_o = lvl_q;

  // R7
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick_i && win_last) |-> $stable(lvl_q));
endmodule

// File: rtl/agc_level_cmp.sv
module agc_level_cmp #(
  parameter int SAMPLE_W   = 16,
  parameter int HYST_SHIFT = 4
) (
  input  logic [SAMPLE_W-1:0] level_i,
  input  logic [SAMPLE_W-1:0] target_i,
  output logic                loud_o,
  output logic                quiet_o
);
  logic [SAMPLE_W-1:0] margin;
  logic [SAMPLE_W:0]   upper;
  logic [SAMPLE_W-1:0] lower;

  always_comb begin
    margin  = target_i >> HYST_SHIFT;
    upper   = {1'b0, target_i} + {1'b0, margin};
    lower   = target_i - margin;
    loud_o  = ({1'b0, level_i} > upper);
    quiet_o = (level_i < lower);
  end
endmodule

// File: rtl/agc_step_timer.sv
module agc_step_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic             active_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             fire_o
);
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             cnt_en;

  always_comb begin
    fire_o  = tick_i && active_i && !clr_i && (cnt_q >= limit_i);
    cnt_en  = clr_i || tick_i;
    cnt_nxt = cnt_q;
    if (clr_i || !active_i || fire_o) cnt_nxt = '0;
    else                              cnt_nxt = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/agc_gain_ctrl.sv
module agc_gain_ctrl
  import agc_pkg::*;
#(
  parameter int SAMPLE_W   = 16,
  parameter int TIME_W     = 10,
  parameter int WIN_LEN    = 256,
  parameter int HYST_SHIFT = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       enable_i,
  input  logic                       sample_vld_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic        [SAMPLE_W-1:0] target_i,
  input  logic        [TIME_W-1:0]   attack_i,
  input  logic        [TIME_W-1:0]   decay_i,
  input  logic        [GAIN_W-1:0]   fixed_gain_i,
  output logic        [GAIN_W-1:0]   gain_o
);
  localparam logic [GAIN_W-1:0] CODE_TOP = GAIN_W'(GAIN_MAX_CODE);

  logic [1:0]          rst_sync_q;
  logic                rst_q_n;
  logic [SAMPLE_W-1:0] level;
  logic                loud, quiet;
  logic [DIR_COUNT-1:0] dir_active, dir_fire;
  logic [TIME_W-1:0]   dir_limit [DIR_COUNT];
  logic [GAIN_W-1:0]   gain_q, gain_nxt, fixed_clamped;
  logic                past_ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  agc_peak_meter #(.SAMPLE_W(SAMPLE_W), .WIN_LEN(WIN_LEN)) u_meter (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .tick_i   (sample_vld_i),
    .sample_i (sample_i),
    .level_o  (level)
  );

  agc_level_cmp #(.SAMPLE_W(SAMPLE_W), .HYST_SHIFT(HYST_SHIFT)) u_cmp (
    .level_i  (level),
    .target_i (target_i),
    .loud_o   (loud),
    .quiet_o  (quiet)
  );

  assign dir_active[DIR_DOWN] = loud;
  assign dir_active[DIR_UP]   = quiet;
  assign dir_limit[DIR_DOWN]  = attack_i;
  assign dir_limit[DIR_UP]    = decay_i;

  for (genvar d = 0; d < DIR_COUNT; d++) begin : g_dir
    agc_step_timer #(.CNT_W(TIME_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_q_n),
      .clr_i    (!enable_i),
      .tick_i   (sample_vld_i),
      .active_i (dir_active[d]),
      .limit_i  (dir_limit[d]),
      .fire_o   (dir_fire[d])
    );
  end

  always_comb begin
    fixed_clamped = (fixed_gain_i > CODE_TOP) ? CODE_TOP : fixed_gain_i;
    gain_nxt      = gain_q;
    if (!enable_i)
      gain_nxt = fixed_clamped;
    else if (dir_fire[DIR_DOWN] && gain_q != '0)
      gain_nxt = gain_q - 1'b1;
    else if (dir_fire[DIR_UP] && gain_q < CODE_TOP)
      gain_nxt = gain_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) gain_q <= '0;
    else          gain_q <= gain_nxt;
  end

  assign gain_o = gain_q;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) past_ok_q <= 1'b0;
    else          past_ok_q <= 1'b1;
  end

  // R2
  gain_range_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    gain_q <= CODE_TOP);

  // R3
  soft_step_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    past_ok_q && $past(enable_i) |->
      (gain_q == $past(gain_q)) || (gain_q == $past(gain_q) + GAIN_W'(1)) ||
      (gain_q + GAIN_W'(1) == $past(gain_q)));

  // R9
  no_valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    past_ok_q && $past(enable_i) && !$past(sample_vld_i) |-> $stable(gain_q));

  // R4
  attack_dir_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    past_ok_q && $past(enable_i && loud) |-> gain_q <= $past(gain_q));

  // R5
  decay_dir_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    past_ok_q && $past(enable_i && quiet) |-> gain_q >= $past(gain_q));

  // R6
  band_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    past_ok_q && $past(enable_i && !loud && !quiet) |-> $stable(gain_q));

  // R8
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    past_ok_q && $past(!enable_i) |->
      gain_q == (($past(fixed_gain_i) > CODE_TOP) ? CODE_TOP : $past(fixed_gain_i)));
endmodule

// File: tb/agc_gain_ctrl_test.sv
`timescale 1ns/1ps
module agc_gain_ctrl_test;
  localparam int SW = 16;
  localparam int TW = 10;
  localparam int WIN = 256;
  localparam int NV = 9;
  // columns: amplitude, target, attack, decay, start code, enabled samples, expected code, requirement
  localparam int VEC [NV][8] = '{
    '{20000, 8000, 3, 0, 40,  40, 30, 4},  // R4 loud, every 4th sample
    '{20000, 8000, 0, 0,  5,  40,  0, 2},  // R2 floor saturation
    '{ 1000, 8000, 0, 7, 40,  80, 50, 5},  // R5 quiet, every 8th sample
    '{ 1000, 8000, 0, 1, 75,  40, 80, 2},  // R2 ceiling saturation
    '{ 8500, 8000, 0, 0, 40, 100, 40, 6},  // R6 upper band edge
    '{ 7500, 8000, 0, 0, 40, 100, 40, 6},  // R6 lower band edge
    '{ 8501, 8000, 9, 0, 40, 100, 30, 4},  // R4 just above band
    '{ 7499, 8000, 0, 9, 40, 100, 50, 5},  // R5 just below band
    '{    0,    0, 0, 0, 20, 100, 20, 6}   // R6 zero target
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic vld = 1'b0;
  logic signed [SW-1:0] sample = '0;
  logic [SW-1:0] target = '0;
  logic [TW-1:0] attack = '0, decay = '0;
  logic [6:0] fixed = '0;
  logic [6:0] gain;

  int checks = 0, fails = 0, total = 0, step_viol = 0;
  logic neg = 1'b0;
  logic [6:0] prev_gain = '0;

  always #2.5 clk = ~clk;

  agc_gain_ctrl uut (
    .clk(clk), .rst_n(rst_n), .enable_i(enable), .sample_vld_i(vld),
    .sample_i(sample), .target_i(target), .attack_i(attack), .decay_i(decay),
    .fixed_gain_i(fixed), .gain_o(gain)
  );

  // R3 monitor: one code at most per clock while enabled
  always @(posedge clk) begin
    #1;
    if (rst_n && enable) begin
      if ((int'(gain) - int'(prev_gain) > 1) || (int'(prev_gain) - int'(gain) > 1))
        step_viol++;
    end
    prev_gain = gain;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic feed(input int amp, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      vld = 1'b1;
      sample = neg ? SW'(-amp) : SW'(amp);
      neg = ~neg;
      total++;
    end
    @(negedge clk);
    vld = 1'b0;
  endtask

  task automatic prime(input int amp, input int g0);
    @(negedge clk);
    enable = 1'b0;
    fixed = 7'(g0);
    feed(amp, ((WIN - (total % WIN)) % WIN) + WIN);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    enable = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(gain == 7'd0, "R1 reset code", gain, 0);

    for (int v = 0; v < NV; v++) begin
      target = SW'(VEC[v][1]);
      attack = TW'(VEC[v][2]);
      decay  = TW'(VEC[v][3]);
      prime(VEC[v][0], VEC[v][4]);
      check(gain == 7'(VEC[v][4]), "R8 fixed code while disabled", gain, VEC[v][4]);
      enable = 1'b1;
      feed(VEC[v][0], VEC[v][5]);
      check(gain == 7'(VEC[v][6]), $sformatf("R%0d vector %0d", VEC[v][7], v), gain, VEC[v][6]);
      check(step_viol == 0, "R3 soft step", step_viol, 0);
    end

    // R9: no strobe, no change, then exactly one step
    target = 16'd8000; attack = '0; decay = '0;
    prime(20000, 40);
    enable = 1'b1;
    repeat (30) @(negedge clk);
    check(gain == 7'd40, "R9 hold without strobe", gain, 40);
    feed(20000, 1);
    check(gain == 7'd39, "R3 single step per sample", gain, 39);

    // R8: fixed code above range clamps to 80
    @(negedge clk);
    enable = 1'b0;
    fixed = 7'd100;
    repeat (2) @(negedge clk);
    check(gain == 7'd80, "R8 fixed code clamp", gain, 80);

    // R7: level reacts only at window end
    prime(1000, 40);
    enable = 1'b1;
    feed(20000, 10);
    check(gain == 7'd50, "R7 stale level inside window", gain, 50);
    feed(20000, WIN - 10);
    check(gain == 7'd80, "R7 window end, R2 ceiling", gain, 80);
    feed(20000, 10);
    check(gain == 7'd70, "R7 new level after window", gain, 70);

    // R7: most negative sample counts at full magnitude
    target = 16'd30000;
    prime(32768, 40);
    enable = 1'b1;
    feed(32768, 5);
    check(gain == 7'd35, "R7 most negative magnitude", gain, 35);
    check(step_viol == 0, "R3 soft step overall", step_viol, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule